// File: doc/BRIEF.md
# Synchronous Burst RAM Sequencer with Wait Signalling

This block sits on the device side of a synchronous burst memory bus, in front of a single-port array of 16-bit words. A host opens a burst by pulling chip enable and address valid low together for one rising clock edge. On that edge the block latches the start word address, the direction and the burst configuration. It then holds its wait output high for the initial latency, streams words out of or into the array one per clock, and steps the word address as the configured burst mode demands.

The burst configuration arrives on plain input pins that are sampled at the start edge. A length code selects a fixed 4, 8, 16 or 32 word burst or a continuous one. For fixed lengths, a wrap flag selects between wrapping inside an aligned block and counting linearly. A latency count and a fixed/variable latency flag set the initial delay. A refresh-collision input, sampled at the start edge, lengthens variable read latency by a parameterised number of cycles. A linear burst that runs off the end of a row (`ROW_WORDS`, 128 or 256) stalls with wait high for `ROW_GAP` cycles. The host may stop the clock low at any time; all state then holds, and output enable alone decides whether read data is driven.

States: `ST_IDLE` (no burst), `ST_LAT` (initial latency), `ST_XFER` (one word per edge), `ST_ROWW` (row-crossing stall), `ST_DONE` (fixed linear burst used up). Transitions: any state to `ST_LAT` on a start edge. `ST_LAT` to `ST_XFER` when the latency count runs out. `ST_XFER` to `ST_ROWW` after the last word of a row in linear bursts. `ST_ROWW` to `ST_XFER` when the stall ends. `ST_XFER` to `ST_DONE` after the last word of a fixed linear burst. Any state to `ST_IDLE` on an edge where chip enable is high, or on reset.

Top module: `burst_ram_seq`

## Requirements
- R1: On a rising edge with ce_n=0 and adv_n=0, the block latches addr as the start word address and the direction (we_n=1 read, we_n=0 write). This holds even when a burst is already in progress, in which case the new burst replaces it.
- R2: With effective latency L, wait_o is high during the L cycles that follow the start edge and is low after the L-th edge. A read drives the start word on dq_o during the cycle after that edge. A write stores din from the next rising edge onward.
- R3: Length codes 0,1,2,3 (cfg_len) select 4, 8, 16 or 32 words. With cfg_wrap=1, the address increments modulo the burst length inside the block aligned to that length, and the burst continues until chip enable rises.
- R4: With cfg_wrap=0 and a fixed length code, exactly that many words transfer at linear addresses. After the last word, wait_o and dq_oe stay low and nothing more is written.
- R5: Length codes 4 to 7 select a continuous linear burst that runs until chip enable rises.
- R6: In linear bursts (fixed non-wrapping or continuous), a word transferred at the last address of a ROW_WORDS row is followed by ROW_GAP cycles with wait_o high. The burst then resumes at the first word of the next row.
- R7: With cfg_var_lat=0, L equals cfg_lat (0 counts as 1). With cfg_var_lat=1, a read whose start edge sees refresh_req=1 gets L = cfg_lat + REFRESH_EXTRA. Writes always use L = cfg_lat.
- R8: While the clock is held low, wait_o, dq_o and the burst position hold. When the clock restarts, the burst continues with the next word.
- R9: dq_oe is high only during read transfer cycles with oe_n=0 and ce_n=0. oe_n=1 forces it low at once, without disturbing the burst.
- R10: A rising edge with ce_n=1 ends any burst: wait_o and dq_oe are low after it.
- R11: After reset, wait_o and dq_oe are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active, may be stopped low |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address valid |
| we_n | input | 1 | Direction at start edge, low for write |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Start word address |
| din | input | DW | Write data |
| refresh_req | input | 1 | Refresh collision pending at start edge |
| cfg_len | input | 3 | Burst length code |
| cfg_wrap | input | 1 | Wrap inside aligned block for fixed lengths |
| cfg_var_lat | input | 1 | Variable latency mode |
| cfg_lat | input | 4 | Latency count |
| wait_o | output | 1 | High while data is not ready |
| dq_o | output | DW | Read data |
| dq_oe | output | 1 | Read data drive enable |

## Verification
The bench builds, for each burst, a queue of per-cycle expectations: L wait cycles after the start edge, one entry per word with its address, ROW_GAP wait entries after each row end, and idle entries once a fixed linear burst is used up. It pops one entry at every falling edge. Because the state only changes on rising edges, the entry checked at the falling edge after edge k reflects all registers updated at edge k. Read words are compared in that same half cycle. A write word is driven there and counted as stored at the following rising edge, so the last queued word of a burst is never counted as written, since chip enable rises or a new start replaces it. Clock stops and output-enable toggles happen while the clock is low and are checked after a settling delay.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAT,
        ST_XFER,
        ST_ROWW,
        ST_DONE
    } seq_state_t;

    // log2 of a fixed burst length: code 0..3 -> 2..5
    function automatic logic [2:0] len_log2(input logic [2:0] code);
        return 3'(code[1:0]) + 3'd2;
    endfunction

    function automatic logic len_is_cont(input logic [2:0] code);
        return code[2];
    endfunction

endpackage

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
    parameter int AW     = 9,
    parameter int ROW_LG = 7
) (
    input  logic [AW-1:0] cur,
    input  logic [2:0]    len_lg,
    input  logic          wrap_en,
    output logic [AW-1:0] nxt,
    output logic          row_end
);
    logic [AW-1:0] mask;
    logic [AW-1:0] inc;

    always_comb begin
        mask    = (AW'(1) << len_lg) - AW'(1);
        inc     = cur + AW'(1);
        nxt     = wrap_en ? ((cur & ~mask) | (inc & mask)) : inc;
        row_end = &cur[ROW_LG-1:0];
    end
endmodule

// File: rtl/burst_word_array.sv
module burst_word_array #(
    parameter int AW = 9,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[a] <= wdata;
    end

    assign rdata = mem[a];
endmodule

// File: rtl/burst_ram_seq.sv
module burst_ram_seq
    import burst_seq_pkg::*;
#(
    parameter int AW            = 9,
    parameter int DW            = 16,
    parameter int ROW_WORDS     = 128,
    parameter int REFRESH_EXTRA = 3,
    parameter int ROW_GAP       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          refresh_req,
    input  logic [2:0]    cfg_len,
    input  logic          cfg_wrap,
    input  logic          cfg_var_lat,
    input  logic [3:0]    cfg_lat,
    output logic          wait_o,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe
);
    localparam int ROW_LG = $clog2(ROW_WORDS);
    localparam int CW     = $clog2(16 + REFRESH_EXTRA + ROW_GAP) + 1;

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] cur_q;
    logic [5:0]    left_q;
    logic          is_wr_q, wrap_q, cont_q;
    logic [2:0]    len_lg_q;

    logic          start;
    logic [CW-1:0] lat_fixed, lat_eff;
    logic [AW-1:0] nxt_addr;
    logic          row_end;
    logic          wrap_en;
    logic          last_word;
    logic          arr_we;

    assign start     = !ce_n && !adv_n;
    assign wrap_en   = wrap_q && !cont_q;
    assign last_word = !cont_q && !wrap_q && (left_q == 6'd1);
    assign arr_we    = (state_q == ST_XFER) && is_wr_q && !ce_n && adv_n;

    always_comb begin
        lat_fixed = (cfg_lat == 4'd0) ? CW'(1) : CW'(cfg_lat);
        lat_eff   = lat_fixed;
        if (cfg_var_lat && we_n && refresh_req)
            lat_eff = lat_fixed + CW'(REFRESH_EXTRA);
    end

    burst_addr_step #(.AW(AW), .ROW_LG(ROW_LG)) u_step (
        .cur     (cur_q),
        .len_lg  (len_lg_q),
        .wrap_en (wrap_en),
        .nxt     (nxt_addr),
        .row_end (row_end)
    );

    burst_word_array #(.AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .wr_en (arr_we),
        .a     (cur_q),
        .wdata (din),
        .rdata (dq_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ce_n) begin
            state_d = ST_IDLE;
        end else if (!adv_n) begin
            state_d = ST_LAT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_LAT:  if (cnt_q == '0) state_d = ST_XFER;
                ST_XFER: begin
                    if (last_word)                state_d = ST_DONE;
                    else if (!wrap_en && row_end) state_d = ST_ROWW;
                end
                ST_ROWW: if (cnt_q == '0) state_d = ST_XFER;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cur_q    <= '0;
            left_q   <= '0;
            is_wr_q  <= 1'b0;
            wrap_q   <= 1'b0;
            cont_q   <= 1'b0;
            len_lg_q <= 3'd2;
        end else if (!ce_n) begin
            if (!adv_n) begin
                cur_q    <= addr;
                is_wr_q  <= !we_n;
                wrap_q   <= cfg_wrap;
                cont_q   <= len_is_cont(cfg_len);
                len_lg_q <= len_log2(cfg_len);
                left_q   <= 6'd1 << len_log2(cfg_len);
                cnt_q    <= lat_eff - CW'(1);
            end else begin
                unique case (state_q)
                    ST_LAT, ST_ROWW: if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                    ST_XFER: begin
                        cur_q  <= nxt_addr;
                        left_q <= left_q - 6'd1;
                        if (!last_word && !wrap_en && row_end)
                            cnt_q <= CW'(ROW_GAP - 1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        wait_o = (state_q == ST_LAT) || (state_q == ST_ROWW);
        dq_oe  = (state_q == ST_XFER) && !is_wr_q && !oe_n && !ce_n;
    end

    a_r1_capture_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cur_q == $past(addr)));

    a_r2_wait_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> wait_o);

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!wait_o && !dq_oe));

    a_r6_gap_on_new_row: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ROWW) |-> (cur_q[ROW_LG-1:0] == '0));

    a_r3_wrap_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && wrap_en && !ce_n && adv_n)
        |=> ((cur_q >> len_lg_q) == ($past(cur_q) >> len_lg_q)));

    a_r7_write_lat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !we_n) |=> (cnt_q == $past(lat_fixed) - CW'(1)));

endmodule

// File: tb/sim_burst_ram_seq.sv
module sim_burst_ram_seq;
    localparam int PERIOD = 10;
    localparam int AW     = 9;
    localparam int DW     = 16;
    localparam int ROW    = 128;
    localparam int EXTRA  = 3;
    localparam int GAP    = 2;
    localparam int DEPTH  = 1 << AW;

    logic clk = 1'b0, clk_run = 1'b1, rst_n = 1'b0;
    logic ce_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic refresh_req = 1'b0;
    logic [2:0] cfg_len = 3'd0;
    logic cfg_wrap = 1'b0, cfg_var_lat = 1'b0;
    logic [3:0] cfg_lat = 4'd1;
    logic wait_o, dq_oe;
    logic [DW-1:0] dq_o;

    int tests = 0, fails = 0;
    int mem_m [DEPTH];
    bit known [DEPTH];
    int ek[$];
    int ea[$];

    always #(PERIOD/2) if (clk_run) clk = ~clk;

    burst_ram_seq #(.AW(AW), .DW(DW), .ROW_WORDS(ROW), .REFRESH_EXTRA(EXTRA),
                    .ROW_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .refresh_req(refresh_req),
        .cfg_len(cfg_len), .cfg_wrap(cfg_wrap), .cfg_var_lat(cfg_var_lat),
        .cfg_lat(cfg_lat), .wait_o(wait_o), .dq_o(dq_o), .dq_oe(dq_oe));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // expectation queue: kind 0 = wait, 1 = data at address, 2 = ended
    task automatic build(input int a0, input int lenc, input bit wrap,
                         input int lat, input int n);
        int a = a0;
        int words = 0;
        bit cont = (lenc >= 4);
        int nw = 4 << (lenc & 3);
        bit wr_blk = wrap && !cont;
        ek.delete(); ea.delete();
        for (int i = 0; i < lat; i++) begin ek.push_back(0); ea.push_back(0); end
        while (ek.size() < n) begin
            if (!cont && !wrap && words == nw) begin
                ek.push_back(2); ea.push_back(0);
            end else begin
                bit rend;
                ek.push_back(1); ea.push_back(a);
                words++;
                if (wr_blk) begin
                    a = (a & ~(nw - 1)) | ((a + 1) & (nw - 1));
                end else begin
                    rend = ((a + 1) % ROW) == 0;
                    a = (a + 1) % DEPTH;
                    if (rend && !(!cont && words == nw))
                        for (int g = 0; g < GAP; g++) begin ek.push_back(0); ea.push_back(0); end
                end
            end
        end
    endtask

    // called at a falling edge
    task automatic burst(input string tag, input int a0, input bit wr, input int lenc,
                         input bit wrap, input bit varm, input bit refr, input int lat,
                         input int n, input int stop_at, input bit keep_ce);
        int leff = (lat < 1) ? 1 : lat;
        if (varm && !wr && refr) leff += EXTRA;
        build(a0, lenc, wrap, leff, n);
        ce_n = 1'b0; adv_n = 1'b0; we_n = !wr; addr = AW'(a0);
        cfg_len = 3'(lenc); cfg_wrap = wrap; cfg_var_lat = varm;
        cfg_lat = 4'(lat); refresh_req = refr; oe_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            adv_n = 1'b1; refresh_req = 1'b0;
            case (ek[k])
                0: begin
                    chk(wait_o == 1'b1, {tag, " wait high"}, int'(wait_o), 1);
                    chk(dq_oe == 1'b0, {tag, " no drive in wait"}, int'(dq_oe), 0);
                end
                1: begin
                    chk(wait_o == 1'b0, {tag, " wait low on data"}, int'(wait_o), 0);
                    if (!wr) begin
                        chk(dq_oe == 1'b1, {tag, " read drive R9"}, int'(dq_oe), 1);
                        if (known[ea[k]])
                            chk(int'(dq_o) == mem_m[ea[k]], {tag, " read data"},
                                int'(dq_o), mem_m[ea[k]]);
                    end else begin
                        chk(dq_oe == 1'b0, {tag, " write no drive R9"}, int'(dq_oe), 0);
                        din = DW'(ea[k] * 37 + k * 5 + 11);
                        if (k < n - 1) begin
                            mem_m[ea[k]] = int'(din);
                            known[ea[k]] = 1'b1;
                        end
                    end
                end
                default: begin
                    chk(wait_o == 1'b0, {tag, " R4 ended wait"}, int'(wait_o), 0);
                    chk(dq_oe == 1'b0, {tag, " R4 ended drive"}, int'(dq_oe), 0);
                end
            endcase
            if (k == stop_at) begin
                logic w0;
                logic [DW-1:0] d0;
                w0 = wait_o; d0 = dq_o;
                clk_run = 1'b0;
                #(5*PERIOD);
                chk(wait_o == w0, {tag, " R8 wait held"}, int'(wait_o), int'(w0));
                chk(dq_o == d0, {tag, " R8 data held"}, int'(dq_o), int'(d0));
                oe_n = 1'b1; #1;
                chk(dq_oe == 1'b0, {tag, " R9 oe_n high"}, int'(dq_oe), 0);
                oe_n = 1'b0; #1;
                chk(dq_oe == (ek[k] == 1 && !wr), {tag, " R9 oe_n low again"},
                    int'(dq_oe), int'(ek[k] == 1 && !wr));
                clk_run = 1'b1;
            end
        end
        if (!keep_ce) begin
            ce_n = 1'b1;
            @(negedge clk);
            chk(wait_o == 1'b0, {tag, " R10 abort wait"}, int'(wait_o), 0);
            chk(dq_oe == 1'b0, {tag, " R10 abort drive"}, int'(dq_oe), 0);
        end
    endtask

    initial begin
        #(PERIOD*100000);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mem_m[i] = 0; known[i] = 1'b0; end
        repeat (3) @(negedge clk);
        chk(wait_o == 1'b0, "R11 reset wait", int'(wait_o), 0);
        chk(dq_oe == 1'b0, "R11 reset drive", int'(dq_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 R6 continuous write across a row end
        burst("R5_R6_R1 cont write", 120, 1, 4, 0, 0, 0, 3, 30, -1, 0);
        // R2 R6 R8 read back with clock stop
        burst("R2_R6_R8 cont read", 118, 0, 5, 0, 0, 0, 3, 30, 12, 0);
        // R3 fixed 8 wrap write then variable-latency read with refresh
        burst("R3 wrap8 write", 133, 1, 1, 1, 0, 0, 2, 14, -1, 0);
        burst("R3_R7 wrap8 var refresh read", 130, 0, 1, 1, 1, 1, 2, 20, 6, 0);
        burst("R7 var no refresh lat1", 121, 0, 0, 1, 1, 0, 1, 10, -1, 0);
        // R7 write ignores refresh in variable mode
        burst("R7 var write fixed lat", 200, 1, 2, 1, 1, 1, 2, 12, -1, 0);
        burst("R3 wrap16 read", 204, 0, 2, 1, 0, 0, 2, 22, -1, 0);
        // R4 fixed linear over a row end
        burst("R4_R6 len4 linear", 126, 0, 0, 0, 0, 0, 2, 12, -1, 0);
        // R10 abort early
        burst("R10 abort", 122, 0, 7, 0, 0, 0, 2, 5, -1, 0);
        // R1 restart during a burst
        burst("R1 first", 124, 0, 6, 0, 0, 0, 2, 6, -1, 1);
        burst("R1 restarted", 128, 0, 1, 1, 0, 0, 2, 10, -1, 0);
        // R3 32-word block
        burst("R3 wrap32 write", 300, 1, 3, 1, 0, 0, 4, 40, -1, 0);
        burst("R3 wrap32 read", 310, 0, 3, 1, 0, 0, 1, 40, -1, 0);
        burst("R4 len16 linear write", 250, 1, 2, 0, 0, 0, 2, 24, -1, 0);
        burst("R4 len16 linear read", 250, 0, 2, 0, 0, 0, 2, 24, -1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule